// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the host-facing front end of a cursor-overlay peripheral. The host sees four word-aligned locations: two that load a shared indirect pointer one byte at a time, and two data windows. One window reaches a small file of byte-wide control registers. The other reaches a 512 x 16-bit cursor pattern RAM. Both windows move the pointer forward by one after every access. A driver can therefore load a start index once and then stream a run of registers or pattern words with no further address writes.

Byte-wide values travel on a 16-bit bus. On writes only the low lane is used. On reads the byte is copied into both lanes. Pattern words use the full 16 bits. Control-register indices past the end of the file read as zero and ignore writes. The pointer keeps only the bits that the RAM needs, so it wraps from the last pattern word back to zero.

Top module: `cursor_ifc_port`

## Requirements
- R1: The location is chosen by `port`, and an access takes place in any cycle with `req` high. `we` high marks a write and `we` low a read. The encodings are 0 = pointer low byte, 1 = pointer high byte, 2 = pattern data, 3 = control-register data.
- R2: Writing location 0 loads pointer bits 7:0 from `wdata[7:0]`. Writing location 1 loads pointer bit 8 from `wdata[0]`, and the other `wdata` bits are ignored. Reading location 0 returns the pointer low byte in both lanes. Reading location 1 returns pointer bit 8, zero-extended to a byte, in both lanes. No access to location 0 or 1 changes the pointer in any other way.
- R3: Every access to location 2 or 3, read or write, adds one to the pointer after that access.
- R4: The pointer is 9 bits wide and wraps from 0x1FF to 0x000 when it advances.
- R5: A control-register write at index 0..12 stores `wdata[7:0]`. The high halves at indices 2, 4, 6, 8, 10 and 12 keep only bits 3:0, and their upper bits read as zero.
- R6: A control-register read returns the addressed byte in both lanes, as `{v, v}`.
- R7: A pattern-data write stores the full 16-bit word at the pointer index 0..511. A pattern-data read returns that word.
- R8: Control-register indices 13..511 read as zero, and writes to them change no register.
- R9: After reset the pointer is zero and all control registers hold zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access strobe, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| port | input | 2 | Location select (0 ptr-lo, 1 ptr-hi, 2 pattern, 3 register) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the current access |

## Verification
The bench builds the block with its default parameters: a 9-bit pointer, 13 control registers and a 4-bit high half. At these values a full pass over all 512 pattern words is short. The same pass drives the pointer through its wrap back to zero, and the bench then reads back every word. A small register file also leaves the whole undefined range 13..511 reachable, so the bench can probe its first and last index and then confirm that every real register is intact.

// File: rtl/cursor_ifc_port.sv
module cursor_ifc_port #(
  parameter int PTR_W  = 9,
  parameter int NREG   = 13,
  parameter int HI_W   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [1:0]  port,
  input  logic [15:0] wdata,
  output logic [15:0] rdata
);

  localparam int DEPTH = 1 << PTR_W;
  localparam int IW    = $clog2(NREG);
  localparam logic [1:0] P_LO = 2'd0, P_HI = 2'd1, P_MAP = 2'd2, P_REG = 2'd3;

  logic [PTR_W-1:0] ptr;
  logic [15:0]      mem [DEPTH];
  logic [7:0]       regs [NREG];
  logic [15:0]      ptr_ext;
  logic             reg_ok, is_hi;
  logic [IW-1:0]    idx;
  logic [7:0]       reg_q;

  assign ptr_ext = 16'(ptr);
  assign reg_ok  = ptr_ext < 16'(NREG);
  assign idx     = ptr[IW-1:0];
  assign is_hi   = reg_ok && !idx[0] && (idx != '0);
  assign reg_q   = reg_ok ? regs[idx] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (req) begin
      unique case (port)
        P_LO:  if (we) ptr[7:0] <= wdata[7:0];
        P_HI:  if (we) ptr[PTR_W-1:8] <= wdata[PTR_W-9:0];
        default: ptr <= ptr + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (req && we && port == P_REG && reg_ok) begin
      regs[idx] <= is_hi ? {{(8-HI_W){1'b0}}, wdata[HI_W-1:0]} : wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (req && we && port == P_MAP) mem[ptr] <= wdata;
  end

  always_comb begin
    unique case (port)
      P_LO:    rdata = {ptr_ext[7:0], ptr_ext[7:0]};
      P_HI:    rdata = {ptr_ext[15:8], ptr_ext[15:8]};
      P_MAP:   rdata = mem[ptr];
      default: rdata = {reg_q, reg_q};
    endcase
  end

  // R3 and R4: data accesses step the pointer modulo its width
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    req && port[1] |=> ptr == $past(ptr) + 1'b1);

  a_r2_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
    req && we && port == P_LO |=> ptr[7:0] == $past(wdata[7:0]));

  a_r2_addr_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req && !we && !port[1] |=> $stable(ptr));

  a_r8_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    req && !we && port == P_REG && !reg_ok |-> rdata == 16'h0000);

  a_r5_hi_masked: assert property (@(posedge clk) disable iff (!rst_n)
    req && !we && port == P_REG && is_hi |-> rdata[7:HI_W] == '0);

  a_r6_dup_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    req && !we && port == P_REG |-> rdata[15:8] == rdata[7:0]);

endmodule

// File: tb/tb_cursor_ifc_port.sv
module tb_cursor_ifc_port;
  localparam int CLK_P = 10;
  localparam int NREG  = 13;

  logic        clk = 0, rst_n = 0, req = 0, we = 0;
  logic [1:0]  port = 0;
  logic [15:0] wdata = 0, rdata;
  int errs = 0, checks = 0;
  logic [7:0] model [NREG];

  always #(CLK_P/2) clk = ~clk;

  cursor_ifc_port dut (.clk, .rst_n, .req, .we, .port, .wdata, .rdata);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] p, input logic w, input logic [15:0] d,
                     output logic [15:0] q);
    @(negedge clk);
    req = 1; we = w; port = p; wdata = d;
    #1 q = rdata;
    @(posedge clk); #1;
    req = 0; we = 0;
  endtask

  task automatic set_ptr(input logic [8:0] a);
    logic [15:0] q;
    acc(2'd0, 1, {a[7:0], a[7:0]}, q);
    acc(2'd1, 1, {7'h0, a[8], 7'h0, a[8]}, q);
  endtask

  task automatic expect_ptr(input string tag, input logic [8:0] a);
    logic [15:0] q;
    acc(2'd0, 0, 0, q); chk(tag, q, {a[7:0], a[7:0]});
    acc(2'd1, 0, 0, q); chk(tag, q, {7'h0, a[8], 7'h0, a[8]});
  endtask

  task automatic t_reset;
    logic [15:0] q;
    expect_ptr("R9 pointer after reset", 9'h000);
    for (int i = 0; i < NREG; i++) begin
      acc(2'd3, 0, 0, q); chk("R9 register reset value", q, 16'h0000);
    end
  endtask

  task automatic t_addr;
    logic [15:0] q;
    acc(2'd0, 1, 16'h3535, q);
    acc(2'd1, 1, 16'hFF01, q);
    expect_ptr("R2 pointer byte load", 9'h135);
    expect_ptr("R2 address reads do not advance", 9'h135);
    acc(2'd1, 1, 16'h00FE, q);
    expect_ptr("R2 high load uses bit 0 only", 9'h035);
  endtask

  task automatic t_regs;
    logic [15:0] q;
    logic [7:0] v;
    set_ptr(9'd0);
    for (int i = 0; i < NREG; i++) begin
      v = 8'h5B + 8'(i * 37);
      acc(2'd3, 1, {v, v}, q);
      model[i] = (i != 0 && i % 2 == 0) ? {4'h0, v[3:0]} : v;
    end
    expect_ptr("R3 register writes advance", 9'd13);
    set_ptr(9'd0);
    for (int i = 0; i < NREG; i++) begin
      acc(2'd3, 0, 0, q);
      chk((i != 0 && i % 2 == 0) ? "R5 high half masked" : "R6 register readback",
          q, {model[i], model[i]});
    end
    expect_ptr("R3 register reads advance", 9'd13);
  endtask

  task automatic t_undef;
    logic [15:0] q;
    set_ptr(9'd13);
    acc(2'd3, 1, 16'hFFFF, q);
    set_ptr(9'h1FF);
    acc(2'd3, 1, 16'hA5A5, q);
    expect_ptr("R4 wrap after register write", 9'h000);
    set_ptr(9'd13);
    acc(2'd3, 0, 0, q); chk("R8 undefined index 13 reads zero", q, 16'h0000);
    set_ptr(9'h1FF);
    acc(2'd3, 0, 0, q); chk("R8 undefined index 511 reads zero", q, 16'h0000);
    set_ptr(9'd0);
    for (int i = 0; i < NREG; i++) begin
      acc(2'd3, 0, 0, q); chk("R8 registers untouched", q, {model[i], model[i]});
    end
  endtask

  task automatic t_cmap;
    logic [15:0] q;
    set_ptr(9'd0);
    for (int i = 0; i < 512; i++) acc(2'd2, 1, 16'(i * 16'h0101) ^ 16'h5A3C, q);
    expect_ptr("R4 wrap after full pattern pass", 9'h000);
    for (int i = 0; i < 512; i++) begin
      acc(2'd2, 0, 0, q); chk("R7 pattern word", q, 16'(i * 16'h0101) ^ 16'h5A3C);
    end
    set_ptr(9'd10);
    acc(2'd2, 0, 0, q);
    expect_ptr("R3 pattern read advances", 9'd11);
    set_ptr(9'h1FF);
    acc(2'd2, 1, 16'hC0DE, q);
    expect_ptr("R4 wrap after pattern write", 9'h000);
    set_ptr(9'h1FF);
    acc(2'd2, 0, 0, q); chk("R1 pattern port full word", q, 16'hC0DE);
  endtask

  initial begin
    #(CLK_P * 200000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_addr();
    t_regs();
    t_undef();
    t_cmap();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule